// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block with XOR Macrocells

This block evaluates programmable two-level logic over a shared input bus and feeds the results into a row of macrocells. Each macrocell has a small private set of product terms that are ORed into a private sum. A common pool of product terms can also be steered to any macrocell through a programmable OR array. The macrocell XORs its private sum with its pooled sum. It then drives the result to its output either directly or through a register that behaves as a D or a T flip-flop.

A separate small set of control terms supplies asynchronous clear, asynchronous set and output-enable signals. Each control term can be programmed as an AND of literals or as an OR of literals. Every macrocell picks which control terms drive its clear, its set and its enable.

All programming arrives as static configuration vectors. Loading that configuration, the pads and any interconnect between blocks sit outside this block.

Top module: `pla_logic_block`

## Requirements
- R1: Every term gets two configuration bits per input j. Bit 2j selects the true literal of input j and bit 2j+1 selects its complement. Term t occupies bits [t*2*N_IN +: 2*N_IN] of its vector. A product term is the AND of its selected literals, and a term with no literal selected is 0.
- R2: The private sum of macrocell m is the OR of its N_DED private terms. Those terms are numbered m*N_DED+k in `cfg_ded`.
- R3: Bit m*N_SHR+s of `cfg_or` routes pooled term s into the pooled sum of macrocell m. The pooled sum is the OR of all routed terms, and any subset may be routed.
- R4: In modes 2'b00 and 2'b11 (field `cfg_mode[2m+:2]`) the output is combinational: `mc_out[m]` = `cfg_pol[m]` XOR private sum XOR pooled sum.
- R5: In mode 2'b01 the register loads the XOR of the two sums on each rising clock edge, and `mc_out[m]` = `cfg_pol[m]` XOR register.
- R6: In mode 2'b10 the register inverts on a rising edge when the XOR of the two sums is 1 and holds when it is 0.
- R7: While `rst` is high at a rising edge, each register clears to 0 unless an asynchronous clear or set is active.
- R8: The asynchronous clear of macrocell m is the OR of the control terms selected by `cfg_clr_sel[m*N_CTL+:N_CTL]`. While it is active the register is 0 at once, and clock edges do not change it.
- R9: The asynchronous set is selected by `cfg_set_sel` in the same way. While set alone is active the register is 1 at once. When clear and set are both active, clear wins.
- R10: Control term c is a product term when `cfg_ctl_sum[c]` is 0. When that bit is 1, the term is the OR of its selected literals, and it is 0 when no literal is selected.
- R11: `mc_oe[m]` is the OR of the control terms selected by `cfg_oe_sel[m*N_CTL+:N_CTL]`. It is 1 when no control term is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high register clear |
| in_bus | input | N_IN | Shared logic input bus |
| cfg_ded | input | N_MC*N_DED*2*N_IN | Literal selects of the private terms |
| cfg_shr | input | N_SHR*2*N_IN | Literal selects of the pooled terms |
| cfg_ctl | input | N_CTL*2*N_IN | Literal selects of the control terms |
| cfg_ctl_sum | input | N_CTL | Per control term: 1 = OR of literals, 0 = AND |
| cfg_or | input | N_MC*N_SHR | Pooled-term routing per macrocell |
| cfg_mode | input | 2*N_MC | Macrocell mode, 2 bits each |
| cfg_pol | input | N_MC | Output inversion per macrocell |
| cfg_clr_sel | input | N_MC*N_CTL | Control terms driving the asynchronous clear |
| cfg_set_sel | input | N_MC*N_CTL | Control terms driving the asynchronous set |
| cfg_oe_sel | input | N_MC*N_CTL | Control terms driving the output enable |
| mc_out | output | N_MC | Macrocell outputs |
| mc_oe | output | N_MC | Macrocell output enables |

## Verification
The register properties assume the configuration stays fixed while the block runs. They also assume that in_bus, and with it the control terms, changes only well away from rising clock edges. Finally, they assume that an asynchronous clear or set, once raised, stays up across at least one clock edge. In the stimulus, inputs are driven only at the falling edge or two time units after a rising edge, and every clear or set is held through a full clock period before release. Where a clear and a set overlap, the set is dropped before the clear, because a set left standing alone would otherwise only take effect at the next clock edge.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    MC_COMB     = 2'b00,
    MC_DFF      = 2'b01,
    MC_TFF      = 2'b10,
    MC_COMB_ALT = 2'b11
  } mc_mode_e;

  function automatic logic mode_is_reg(mc_mode_e m);
    return (m == MC_DFF) || (m == MC_TFF);
  endfunction
endpackage

// File: rtl/pla_term_plane.sv
module pla_term_plane #(
  parameter int N_IN   = 36,
  parameter int N_TERM = 32
) (
  input  logic [N_IN-1:0]          in_bus,
  input  logic [N_TERM*2*N_IN-1:0] cfg_lits,
  input  logic [N_TERM-1:0]        sum_mode,
  output logic [N_TERM-1:0]        terms
);
  localparam int W = 2 * N_IN;

  logic [W-1:0] lits;

  genvar j, t;
  generate
    for (j = 0; j < N_IN; j++) begin : g_lit
      assign lits[2*j]   = in_bus[j];
      assign lits[2*j+1] = ~in_bus[j];
    end
    for (t = 0; t < N_TERM; t++) begin : g_term
      logic [W-1:0] mask;
      logic         any_sel;
      logic         and_v;
      logic         or_v;
      assign mask     = cfg_lits[t*W +: W];
      assign any_sel  = |mask;
      assign and_v    = any_sel & (&(~mask | lits));
      assign or_v     = |(mask & lits);
      assign terms[t] = sum_mode[t] ? or_v : and_v;
    end
  endgenerate
endmodule

// File: rtl/pla_macrocell.sv
module pla_macrocell
  import pla_pkg::*;
#(
  parameter int N_DED = 4,
  parameter int N_SHR = 32,
  parameter int N_CTL = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DED-1:0] ded_terms,
  input  logic [N_SHR-1:0] shr_terms,
  input  logic [N_SHR-1:0] or_sel,
  input  logic [N_CTL-1:0] ctl_terms,
  input  mc_mode_e         mode,
  input  logic             pol,
  input  logic [N_CTL-1:0] clr_sel,
  input  logic [N_CTL-1:0] set_sel,
  input  logic [N_CTL-1:0] oe_sel,
  output logic             out,
  output logic             oe,
  output logic             q,
  output logic             xr,
  output logic             ar,
  output logic             ap
);
  logic ded_sum;
  logic shr_sum;
  logic use_reg;

  assign ded_sum = |ded_terms;
  assign shr_sum = |(shr_terms & or_sel);
  assign xr      = ded_sum ^ shr_sum;

  assign ar = |(ctl_terms & clr_sel);
  assign ap = |(ctl_terms & set_sel);
  assign oe = (oe_sel == '0) | (|(ctl_terms & oe_sel));

  always_ff @(posedge clk or posedge ar or posedge ap) begin
    if (ar)       q <= 1'b0;
    else if (ap)  q <= 1'b1;
    else if (rst) q <= 1'b0;
    else begin
      case (mode)
        MC_DFF:  q <= xr;
        MC_TFF:  q <= q ^ xr;
        default: q <= q;
      endcase
    end
  end

  assign use_reg = mode_is_reg(mode);
  assign out     = pol ^ (use_reg ? q : xr);
endmodule

// File: rtl/pla_logic_block.sv
module pla_logic_block
  import pla_pkg::*;
#(
  parameter int N_IN  = 36,
  parameter int N_MC  = 20,
  parameter int N_DED = 4,
  parameter int N_SHR = 32,
  parameter int N_CTL = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_IN-1:0]             in_bus,
  input  logic [N_MC*N_DED*2*N_IN-1:0] cfg_ded,
  input  logic [N_SHR*2*N_IN-1:0]     cfg_shr,
  input  logic [N_CTL*2*N_IN-1:0]     cfg_ctl,
  input  logic [N_CTL-1:0]            cfg_ctl_sum,
  input  logic [N_MC*N_SHR-1:0]       cfg_or,
  input  logic [2*N_MC-1:0]           cfg_mode,
  input  logic [N_MC-1:0]             cfg_pol,
  input  logic [N_MC*N_CTL-1:0]       cfg_clr_sel,
  input  logic [N_MC*N_CTL-1:0]       cfg_set_sel,
  input  logic [N_MC*N_CTL-1:0]       cfg_oe_sel,
  output logic [N_MC-1:0]             mc_out,
  output logic [N_MC-1:0]             mc_oe
);
  localparam int N_DTERM = N_MC * N_DED;

  logic [N_DTERM-1:0] ded_terms;
  logic [N_SHR-1:0]   shr_terms;
  logic [N_CTL-1:0]   ctl_terms;
  logic [N_MC-1:0]    mc_q;
  logic [N_MC-1:0]    mc_xor;
  logic [N_MC-1:0]    mc_ar;
  logic [N_MC-1:0]    mc_ap;

  pla_term_plane #(.N_IN(N_IN), .N_TERM(N_DTERM)) u_ded_plane (
    .in_bus(in_bus), .cfg_lits(cfg_ded), .sum_mode('0), .terms(ded_terms)
  );

  pla_term_plane #(.N_IN(N_IN), .N_TERM(N_SHR)) u_shr_plane (
    .in_bus(in_bus), .cfg_lits(cfg_shr), .sum_mode('0), .terms(shr_terms)
  );

  pla_term_plane #(.N_IN(N_IN), .N_TERM(N_CTL)) u_ctl_plane (
    .in_bus(in_bus), .cfg_lits(cfg_ctl), .sum_mode(cfg_ctl_sum), .terms(ctl_terms)
  );

  genvar m;
  generate
    for (m = 0; m < N_MC; m++) begin : g_mc
      pla_macrocell #(.N_DED(N_DED), .N_SHR(N_SHR), .N_CTL(N_CTL)) u_mc (
        .clk      (clk),
        .rst      (rst),
        .ded_terms(ded_terms[m*N_DED +: N_DED]),
        .shr_terms(shr_terms),
        .or_sel   (cfg_or[m*N_SHR +: N_SHR]),
        .ctl_terms(ctl_terms),
        .mode     (mc_mode_e'(cfg_mode[2*m +: 2])),
        .pol      (cfg_pol[m]),
        .clr_sel  (cfg_clr_sel[m*N_CTL +: N_CTL]),
        .set_sel  (cfg_set_sel[m*N_CTL +: N_CTL]),
        .oe_sel   (cfg_oe_sel[m*N_CTL +: N_CTL]),
        .out      (mc_out[m]),
        .oe       (mc_oe[m]),
        .q        (mc_q[m]),
        .xr       (mc_xor[m]),
        .ar       (mc_ar[m]),
        .ap       (mc_ap[m])
      );
    end
  endgenerate
endmodule

// File: rtl/pla_block_checker.sv
module pla_block_checker #(
  parameter int N_MC  = 20,
  parameter int N_CTL = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_MC-1:0]      mc_q,
  input logic [N_MC-1:0]      mc_xor,
  input logic [N_MC-1:0]      mc_ar,
  input logic [N_MC-1:0]      mc_ap,
  input logic [N_MC-1:0]      mc_oe,
  input logic [2*N_MC-1:0]    cfg_mode,
  input logic [N_MC*N_CTL-1:0] cfg_oe_sel
);
  genvar i;
  generate
    for (i = 0; i < N_MC; i++) begin : g_chk
      AST_ASYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        mc_ar[i] |-> !mc_q[i]); // R8
      AST_SET_ALONE: assert property (@(posedge clk) disable iff (rst)
        (mc_ap[i] && !mc_ar[i] && $stable(mc_ap[i]) && $stable(mc_ar[i])) |-> mc_q[i]); // R9
      AST_D_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode[2*i +: 2] == 2'b01 && !mc_ar[i] && !mc_ap[i])
          ##1 (!mc_ar[i] && !mc_ap[i] && $stable(cfg_mode[2*i +: 2]))
          |-> mc_q[i] == $past(mc_xor[i])); // R5
      AST_T_STEP: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode[2*i +: 2] == 2'b10 && !mc_ar[i] && !mc_ap[i])
          ##1 (!mc_ar[i] && !mc_ap[i] && $stable(cfg_mode[2*i +: 2]))
          |-> mc_q[i] == ($past(mc_q[i]) ^ $past(mc_xor[i]))); // R6
      AST_OE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_sel[i*N_CTL +: N_CTL] == '0) |-> mc_oe[i]); // R11
    end
  endgenerate
endmodule

bind pla_logic_block pla_block_checker #(.N_MC(N_MC), .N_CTL(N_CTL)) u_pla_chk (
  .clk(clk), .rst(rst), .mc_q(mc_q), .mc_xor(mc_xor), .mc_ar(mc_ar),
  .mc_ap(mc_ap), .mc_oe(mc_oe), .cfg_mode(cfg_mode), .cfg_oe_sel(cfg_oe_sel)
);

// File: tb/pla_logic_block_bench.sv
module pla_logic_block_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 36, NM = 20, ND = 4, NS = 32, NC = 8;
  localparam int W = 2 * NI;

  // stimulus in[12:0], expected {out0, out1, out4, oe0}
  localparam logic [16:0] VEC [8] = '{
    {13'h000, 4'b0100}, {13'h003, 4'b1100}, {13'h007, 4'b0110},
    {13'h00F, 4'b1000}, {13'h014, 4'b1010}, {13'h840, 4'b0111},
    {13'h847, 4'b0111}, {13'h813, 4'b1001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0]        in_bus = '0;
  logic [NM*ND*W-1:0]   cfg_ded = '0;
  logic [NS*W-1:0]      cfg_shr = '0;
  logic [NC*W-1:0]      cfg_ctl = '0;
  logic [NC-1:0]        cfg_ctl_sum = '0;
  logic [NM*NS-1:0]     cfg_or = '0;
  logic [2*NM-1:0]      cfg_mode = '0;
  logic [NM-1:0]        cfg_pol = '0;
  logic [NM*NC-1:0]     cfg_clr_sel = '0;
  logic [NM*NC-1:0]     cfg_set_sel = '0;
  logic [NM*NC-1:0]     cfg_oe_sel = '0;
  logic [NM-1:0]        mc_out;
  logic [NM-1:0]        mc_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_logic_block #(.N_IN(NI), .N_MC(NM), .N_DED(ND), .N_SHR(NS), .N_CTL(NC))
  u_pla_logic_block (
    .clk(clk), .rst(rst), .in_bus(in_bus), .cfg_ded(cfg_ded), .cfg_shr(cfg_shr),
    .cfg_ctl(cfg_ctl), .cfg_ctl_sum(cfg_ctl_sum), .cfg_or(cfg_or),
    .cfg_mode(cfg_mode), .cfg_pol(cfg_pol), .cfg_clr_sel(cfg_clr_sel),
    .cfg_set_sel(cfg_set_sel), .cfg_oe_sel(cfg_oe_sel),
    .mc_out(mc_out), .mc_oe(mc_oe)
  );

  function automatic int dpos(int m, int k, int j, int c);
    return (m*ND + k)*W + 2*j + c;
  endfunction
  function automatic int tpos(int t, int j, int c);
    return t*W + 2*j + c;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(logic [12:0] v);
    in_bus = {23'b0, v};
  endtask

  initial begin
    // MC0: comb, private in0&in1, pooled term 0 (in2 & ~in3), enable from ctl2
    cfg_ded[dpos(0,0,0,0)] = 1'b1; cfg_ded[dpos(0,0,1,0)] = 1'b1;
    cfg_shr[tpos(0,2,0)] = 1'b1;   cfg_shr[tpos(0,3,1)] = 1'b1;
    cfg_or[0*NS + 0] = 1'b1;
    cfg_oe_sel[0*NC + 2] = 1'b1;
    // MC1: comb inverted, private terms in4 and in3
    cfg_ded[dpos(1,0,4,0)] = 1'b1; cfg_ded[dpos(1,1,3,0)] = 1'b1;
    cfg_pol[1] = 1'b1;
    // MC2: D, private in5, pooled term 1 (in6)
    cfg_ded[dpos(2,0,5,0)] = 1'b1;
    cfg_shr[tpos(1,6,0)] = 1'b1;
    cfg_or[2*NS + 1] = 1'b1;
    cfg_mode[5:4] = 2'b01;
    cfg_clr_sel[2*NC + 0] = 1'b1; cfg_set_sel[2*NC + 1] = 1'b1;
    // MC3: T, private in7
    cfg_ded[dpos(3,0,7,0)] = 1'b1;
    cfg_mode[7:6] = 2'b10;
    cfg_clr_sel[3*NC + 0] = 1'b1; cfg_set_sel[3*NC + 1] = 1'b1;
    // MC4: alternate comb code, pooled terms 0 and 1 only
    cfg_or[4*NS + 0] = 1'b1; cfg_or[4*NS + 1] = 1'b1;
    cfg_mode[9:8] = 2'b11;
    // control terms: ctl0 = in8 & in12, ctl1 = in9 | in10, ctl2 = in11
    cfg_ctl[tpos(0,8,0)] = 1'b1;  cfg_ctl[tpos(0,12,0)] = 1'b1;
    cfg_ctl[tpos(1,9,0)] = 1'b1;  cfg_ctl[tpos(1,10,0)] = 1'b1;
    cfg_ctl_sum[1] = 1'b1;
    cfg_ctl[tpos(2,11,0)] = 1'b1;

    // reset state
    repeat (3) tick();
    chk("R7", "out2 after reset", mc_out[2], 1'b0);
    chk("R7", "out3 after reset", mc_out[3], 1'b0);
    rst = 1'b0;

    // combinational table
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      drive(VEC[n][16:4]);
      #1;
      chk("R2 R4", "out0", mc_out[0], VEC[n][3]);
      chk("R2 R4", "out1 inverted", mc_out[1], VEC[n][2]);
      chk("R3 R4", "out4 pooled OR", mc_out[4], VEC[n][1]);
      chk("R11", "oe0", mc_oe[0], VEC[n][0]);
      chk("R11", "oe1 default", mc_oe[1], 1'b1);
      chk("R1", "out5 empty terms", mc_out[5], 1'b0);
    end

    // D register
    @(negedge clk); drive(13'h020);
    tick(); chk("R5", "D load 1", mc_out[2], 1'b1);
    drive(13'h060);
    tick(); chk("R5", "D load xor 0", mc_out[2], 1'b0);
    drive(13'h040);
    tick(); chk("R5", "D load pooled 1", mc_out[2], 1'b1);
    chk("R6", "T hold at 0", mc_out[3], 1'b0);

    // T register
    drive(13'h0C0);
    tick(); chk("R6", "T toggle 1", mc_out[3], 1'b1);
    tick(); chk("R6", "T toggle 2", mc_out[3], 1'b0);
    tick(); chk("R6", "T toggle 3", mc_out[3], 1'b1);
    drive(13'h040);
    tick(); chk("R6", "T hold", mc_out[3], 1'b1);

    // product control term and asynchronous clear
    drive(13'h140); #2;
    chk("R10", "product half-true no clear", mc_out[2], 1'b1);
    drive(13'h1140); #1;
    chk("R8", "async clear out2", mc_out[2], 1'b0);
    chk("R8", "async clear out3", mc_out[3], 1'b0);
    tick(); chk("R8", "clear overrides clock", mc_out[2], 1'b0);
    drive(13'h1340); #1;
    chk("R9", "clear beats set", mc_out[2], 1'b0);
    tick(); chk("R9", "clear beats set at edge", mc_out[3], 1'b0);
    drive(13'h1140); #1;
    drive(13'h0040);
    tick(); chk("R5", "D resumes after clear", mc_out[2], 1'b1);

    // sum control term asynchronous set
    drive(13'h400); #1;
    chk("R10", "sum term set out2", mc_out[2], 1'b1);
    chk("R9", "set out3", mc_out[3], 1'b1);
    tick(); chk("R9", "set overrides D", mc_out[2], 1'b1);
    drive(13'h000);
    tick();
    chk("R5", "D loads 0 after set", mc_out[2], 1'b0);
    chk("R6", "T holds set value", mc_out[3], 1'b1);

    // synchronous reset
    drive(13'h020);
    rst = 1'b1;
    tick();
    chk("R7", "sync reset clears T", mc_out[3], 1'b0);
    chk("R7", "sync reset beats D", mc_out[2], 1'b0);
    rst = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule